// File: doc/BRIEF.md
# GPIO Bank Register File with Masked Writes

This block holds the control state for one bank of 32 general-purpose pins. The pins are grouped into four ports of eight. A 32-bit register bus reaches the bank; every port has a configuration byte, a drive-enable byte, a drive-value byte and a read-only input byte. The block drives pad data and pad drive enables from these bytes, and it samples the pad levels through a two-flop synchroniser.

A second address window mirrors the writable registers for atomic per-pin updates. In this window one write carries a select byte in bits 15:8 and the new pin values in bits 7:0. Software can therefore change a single pin without reading the register first. Interrupt-class offsets are decoded by a companion block. This block ignores writes to them and reads them as zero.

The bus accepts a request on every cycle in which `req_valid` is high. A read returns its data one cycle later, qualified by `rsp_valid`.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration, drive-enable and drive-value byte is zero, `pad_oe` and `pad_out` are zero, and `rsp_valid` is low.
- R2: A write to a plain register address loads `req_wdata[7:0]` into all eight pins of that port, and `req_wdata[31:8]` has no effect. A later read returns the byte in bits 7:0 and zero in bits 31:8.
- R3: A write to a masked-window address changes pin n of the port to `req_wdata[n]` only when `req_wdata[8+n]` is 1. Pins whose select bit is 0 keep their value, so a select byte of zero changes nothing.
- R4: A read from a masked-window address returns the plain register byte in bits 7:0 and zero in bits 31:8.
- R5: `pad_oe` for pin n is the AND of that pin's configuration bit and its drive-enable bit. `pad_out` for pin n is its drive-value bit.
- R6: The input register of a port returns the pad levels as they were two clock edges before the read was accepted. This holds whether the pin is driving or not.
- R7: The input register is read-only. A plain write to it changes nothing. The masked window has no input register, so its input address reads zero and ignores writes.
- R8: Addresses outside the bank are ignored. So are the interrupt-class offsets (0x40 to 0x7F relative to a window), unaligned addresses and the masked input offset. Writes to them change nothing, and reads from them return zero.
- R9: Addressing follows a fixed layout. Bank base = BANK_IDX × BANK_STRIDE. Plain register = base + class + 4 × port, with class 0x00 config, 0x10 drive-enable, 0x20 drive-value and 0x30 input. The masked register is the same address plus ALIAS_OFS. Port p controls pad bits 8p+7 to 8p.
- R10: `rsp_valid` is high for exactly one cycle after each accepted read, and never after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request strobe, accepted every cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the shared register map |
| req_wdata | input | 32 | Write data (select byte in 15:8 for the masked window) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad drive enables |

## Verification
A wrong bit in a configuration, drive-enable or drive-value byte reaches `pad_oe` or `pad_out` one cycle after the write that causes it. It also shows in the read data one cycle after the next read of that register. An address decoded to the wrong port or class appears as a write landing on another byte of the pads. A merge error in the masked window appears as a neighbouring pin flipping. A synchroniser of the wrong depth returns input data one edge early or late. The bench compares every output against a behavioural model on every cycle, so each of these faults shows up in the cycle it first reaches a port.

// File: rtl/gpb_pkg.sv
// Shared types and helpers for the GPIO bank.
// Assumes eight pins per port; the masked-write format depends on that.
package gpb_pkg;
    localparam int PORT_PINS = 8;
    localparam int WIN_SIZE  = 'h80;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CFG,
        RK_OE,
        RK_OUT,
        RK_IN
    } reg_kind_e;

    // Next port byte: full load for plain writes, select-merged for masked writes.
    function automatic logic [PORT_PINS-1:0] next_byte(
        input logic [PORT_PINS-1:0]   cur,
        input logic [2*PORT_PINS-1:0] wd,
        input logic                   masked
    );
        logic [PORT_PINS-1:0] sel;
        sel = wd[2*PORT_PINS-1:PORT_PINS];
        if (masked)
            return (cur & ~sel) | (wd[PORT_PINS-1:0] & sel);
        return wd[PORT_PINS-1:0];
    endfunction
endpackage

// File: rtl/gpb_decode.sv
// Address decoder for one bank. It classifies a bus address as a plain or
// masked access to one port's register, or as nothing.
// Assumes: ALIAS_OFS >= 0x80, and the whole map fits in ADDR_W bits.
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BANK_IDX    = 1,
    parameter int BANK_STRIDE = 'h100,
    parameter int ALIAS_OFS   = 'h80,
    parameter int PORTS       = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic              masked,
    output logic [1:0]        port
);
    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(BANK_IDX * BANK_STRIDE);
    localparam logic [ADDR_W-1:0] AOFS  = ADDR_W'(ALIAS_OFS);
    localparam logic [ADDR_W-1:0] WIN   = ADDR_W'(WIN_SIZE);

    logic [ADDR_W-1:0] off_plain;
    logic [ADDR_W-1:0] off_alias;
    logic              in_plain;
    logic              in_alias;
    logic [6:0]        sub;

    // Locate the address inside the plain or the masked window.
    always_comb begin
        off_plain = addr - BASE;
        off_alias = off_plain - AOFS;
        in_plain  = off_plain < WIN;
        in_alias  = off_alias < WIN;
        sub       = in_plain ? off_plain[6:0] : off_alias[6:0];
    end

    // Map the window offset to a register class and port.
    always_comb begin
        masked = in_alias && !in_plain;
        port   = sub[3:2];
        kind   = RK_NONE;
        if ((in_plain || in_alias) && sub[1:0] == 2'b00 && int'(sub[3:2]) < PORTS) begin
            case (sub[6:4])
                3'd0:    kind = RK_CFG;
                3'd1:    kind = RK_OE;
                3'd2:    kind = RK_OUT;
                3'd3:    kind = masked ? RK_NONE : RK_IN;
                default: kind = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpb_port_regs.sv
// Control bytes of one port: configuration, drive-enable and drive-value.
// Each byte takes either a full load or a select-merged update.
// Assumes at most one write strobe is high in any cycle.
module gpb_port_regs
    import gpb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_cfg,
    input  logic                   wr_oe,
    input  logic                   wr_out,
    input  logic                   masked,
    input  logic [2*PORT_PINS-1:0] wd,
    output logic [PORT_PINS-1:0]   cfg_q,
    output logic [PORT_PINS-1:0]   oe_q,
    output logic [PORT_PINS-1:0]   out_q
);
    // Configuration byte update.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= next_byte(cfg_q, wd, masked);
    end

    // Drive-enable byte update.
    always_ff @(posedge clk) begin
        if (!rst_n)     oe_q <= '0;
        else if (wr_oe) oe_q <= next_byte(oe_q, wd, masked);
    end

    // Drive-value byte update.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_out) out_q <= next_byte(out_q, wd, masked);
    end
endmodule

// File: rtl/gpb_sync.sv
// Two-flop synchroniser for the raw pad levels.
// Assumes the pads are asynchronous to clk and carry no pulses shorter than a cycle.
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// One GPIO bank: four ports of eight pins with plain and masked register
// windows, pad drive outputs and a synchronised input register.
// Assumes a bus that presents one request per cycle and needs no back-pressure.
// Interrupt-class offsets belong to a companion block and read as zero here.
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BANK_IDX    = 1,
    parameter int BANK_STRIDE = 'h100,
    parameter int ALIAS_OFS   = 'h80,
    parameter int PORTS       = 4,
    localparam int PINS       = PORTS * PORT_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    reg_kind_e            dec_kind;
    logic                 dec_masked;
    logic [1:0]           dec_port;
    logic                 wr_go;
    logic                 rd_go;
    logic [PORT_PINS-1:0] rd_byte;
    logic [PINS-1:0]      in_sync;
    logic [PORT_PINS-1:0] cfg_a [PORTS];
    logic [PORT_PINS-1:0] oe_a  [PORTS];
    logic [PORT_PINS-1:0] out_a [PORTS];
    logic                 unused_hi;

    assign wr_go     = req_valid && req_write;
    assign rd_go     = req_valid && !req_write;
    assign unused_hi = ^req_wdata[31:16];

    gpb_decode #(
        .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX), .BANK_STRIDE(BANK_STRIDE),
        .ALIAS_OFS(ALIAS_OFS), .PORTS(PORTS)
    ) u_dec (
        .addr(req_addr), .kind(dec_kind), .masked(dec_masked), .port(dec_port)
    );

    gpb_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic hit;
        assign hit = wr_go && (int'(dec_port) == p);

        gpb_port_regs u_regs (
            .clk(clk), .rst_n(rst_n),
            .wr_cfg(hit && dec_kind == RK_CFG),
            .wr_oe (hit && dec_kind == RK_OE),
            .wr_out(hit && dec_kind == RK_OUT),
            .masked(dec_masked),
            .wd(req_wdata[2*PORT_PINS-1:0]),
            .cfg_q(cfg_a[p]), .oe_q(oe_a[p]), .out_q(out_a[p])
        );

        assign pad_oe [p*PORT_PINS +: PORT_PINS] = cfg_a[p] & oe_a[p];
        assign pad_out[p*PORT_PINS +: PORT_PINS] = out_a[p];
    end

    // Select the byte addressed by a read.
    always_comb begin
        case (dec_kind)
            RK_CFG:  rd_byte = cfg_a[dec_port];
            RK_OE:   rd_byte = oe_a[dec_port];
            RK_OUT:  rd_byte = out_a[dec_port];
            RK_IN:   rd_byte = in_sync[dec_port*PORT_PINS +: PORT_PINS];
            default: rd_byte = '0;
        endcase
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            rsp_rdata <= rd_go ? {{(32-PORT_PINS){1'b0}}, rd_byte} : '0;
        end
    end

    // R10
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R8
    dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && dec_kind == RK_NONE) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R3
    empty_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && dec_masked && req_wdata[15:8] == 8'h00)
            |=> ($stable(pad_out) && $stable(pad_oe)));

    // R5
    oe_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pad_oe) |-> $past(wr_go));
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE  = 'h100;
    localparam int ALIAS = 'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    logic [7:0]  m_cfg [4];
    logic [7:0]  m_oe  [4];
    logic [7:0]  m_out [4];
    logic [31:0] m_s1 = '0;
    logic [31:0] m_s2 = '0;
    logic        e_rv = 1'b0;
    logic [31:0] e_rd = '0;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Returns 0 none, 1 cfg, 2 drive-enable, 3 drive-value, 4 input.
    function automatic int classify(input int addr, output int port, output bit msk);
        int off, sub, cls;
        off = addr - BASE;
        msk = 1'b0;
        port = 0;
        if (off >= 0 && off < 'h80) sub = off;
        else if (off >= ALIAS && off < ALIAS + 'h80) begin sub = off - ALIAS; msk = 1'b1; end
        else return 0;
        if (sub % 4 != 0) return 0;
        port = (sub / 4) % 4;
        cls  = sub / 16;
        if (cls > 3) return 0;
        if (cls == 3 && msk) return 0;
        return cls + 1;
    endfunction

    function automatic logic [7:0] merge(input logic [7:0] cur, input logic [31:0] wd, input bit msk);
        logic [7:0] r;
        r = cur;
        for (int i = 0; i < 8; i++)
            if (!msk || wd[8+i]) r[i] = wd[i];
        return r;
    endfunction

    // One bus cycle: drive, advance the model, wait a cycle, compare all outputs.
    task automatic step(input bit v, input bit we, input int addr,
                        input logic [31:0] wd, input logic [31:0] pin, input string req);
        int p, k;
        bit msk;
        logic [31:0] eo, ed;
        req_valid = v; req_write = we; req_addr = 16'(addr); req_wdata = wd; pad_in = pin;
        k = classify(addr, p, msk);
        e_rv = v && !we;
        e_rd = '0;
        if (e_rv) begin
            case (k)
                1: e_rd = {24'h0, m_cfg[p]};
                2: e_rd = {24'h0, m_oe[p]};
                3: e_rd = {24'h0, m_out[p]};
                4: e_rd = {24'h0, m_s2[p*8 +: 8]};
                default: e_rd = '0;
            endcase
        end
        if (v && we) begin
            case (k)
                1: m_cfg[p] = merge(m_cfg[p], wd, msk);
                2: m_oe[p]  = merge(m_oe[p], wd, msk);
                3: m_out[p] = merge(m_out[p], wd, msk);
                default: ;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = pin;
        @(posedge clk);
        @(negedge clk);
        for (int q = 0; q < 4; q++) begin
            eo[q*8 +: 8] = m_cfg[q] & m_oe[q];
            ed[q*8 +: 8] = m_out[q];
        end
        check(pad_oe, eo, "R5");
        check(pad_out, ed, "R9");
        check({31'h0, rsp_valid}, {31'h0, e_rv}, "R10");
        check(rsp_rdata, e_rd, req);
    endtask

    task automatic wr(input int addr, input logic [31:0] wd, input logic [31:0] pin, input string req);
        step(1'b1, 1'b1, addr, wd, pin, req);
    endtask

    task automatic rd(input int addr, input logic [31:0] pin, input string req);
        step(1'b1, 1'b0, addr, 32'h0, pin, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_cfg[i] = '0; m_oe[i] = '0; m_out[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the pads and in every register
        step(1'b0, 1'b0, 0, 32'h0, 32'h0, "R1");
        for (int c = 0; c < 4; c++)
            for (int p = 0; p < 4; p++)
                rd(BASE + c*16 + p*4, 32'h0, "R1");

        // R2: plain writes load the whole byte, upper data ignored
        wr(BASE + 'h00, 32'hFFFF_FF0F, 32'h0, "R2");
        wr(BASE + 'h10, 32'h1234_5633, 32'h0, "R2");
        wr(BASE + 'h20, 32'hDEAD_BEA5, 32'h0, "R2");
        rd(BASE + 'h00, 32'h0, "R2");
        rd(BASE + 'h10, 32'h0, "R2");
        rd(BASE + 'h20, 32'h0, "R2");

        // R9: port 3 and port 2 map onto the upper pad bytes
        wr(BASE + 'h0C, 32'h0000_00FF, 32'h0, "R9");
        wr(BASE + 'h1C, 32'h0000_00F0, 32'h0, "R9");
        wr(BASE + 'h2C, 32'h0000_0081, 32'h0, "R9");
        wr(BASE + 'h28, 32'h0000_007E, 32'h0, "R9");
        rd(BASE + 'h2C, 32'h0, "R9");

        // R3: masked writes touch only selected pins
        wr(BASE + ALIAS + 'h20, 32'h0000_0301, 32'h0, "R3");
        wr(BASE + ALIAS + 'h20, 32'h0000_00FF, 32'h0, "R3");
        wr(BASE + ALIAS + 'h1C, 32'h0000_0C04, 32'h0, "R3");
        wr(BASE + ALIAS + 'h04, 32'h0000_8080, 32'h0, "R3");
        wr(BASE + ALIAS + 'h00, 32'h0000_F000, 32'h0, "R3");
        rd(BASE + 'h20, 32'h0, "R3");
        rd(BASE + 'h1C, 32'h0, "R3");
        rd(BASE + 'h04, 32'h0, "R3");

        // R4: masked-window reads return the plain byte
        rd(BASE + ALIAS + 'h00, 32'h0, "R4");
        rd(BASE + ALIAS + 'h2C, 32'h0, "R4");

        // R6: synchronised input, driving or not
        step(1'b0, 1'b0, 0, 32'h0, 32'hA5C3_3C5A, "R6");
        step(1'b0, 1'b0, 0, 32'h0, 32'hA5C3_3C5A, "R6");
        rd(BASE + 'h30, 32'h0F0F_F0F0, "R6");
        rd(BASE + 'h3C, 32'h0F0F_F0F0, "R6");
        rd(BASE + 'h30, 32'h0F0F_F0F0, "R6");
        rd(BASE + 'h34, 32'hFFFF_FFFF, "R6");
        rd(BASE + 'h38, 32'h1122_3344, "R6");
        rd(BASE + 'h38, 32'h1122_3344, "R6");

        // R7: input register cannot be written; no masked input register
        wr(BASE + 'h30, 32'h0000_FFFF, 32'h1122_3344, "R7");
        wr(BASE + ALIAS + 'h30, 32'h0000_FFFF, 32'h1122_3344, "R7");
        rd(BASE + ALIAS + 'h30, 32'h1122_3344, "R7");
        rd(BASE + 'h30, 32'h1122_3344, "R7");

        // R8: interrupt offsets, unaligned, other banks
        wr(BASE + 'h40, 32'h0000_FFFF, 32'h0, "R8");
        wr(BASE + 'h50, 32'h0000_FFFF, 32'h0, "R8");
        wr(BASE + ALIAS + 'h60, 32'h0000_FFFF, 32'h0, "R8");
        wr(BASE + 'h21, 32'h0000_FF00, 32'h0, "R8");
        wr('h020, 32'h0000_0000, 32'h0, "R8");
        wr('h220, 32'h0000_0000, 32'h0, "R8");
        rd(BASE + 'h40, 32'h0, "R8");
        rd(BASE + 'h70, 32'h0, "R8");
        rd(BASE + 'h22, 32'h0, "R8");
        rd('h000, 32'h0, "R8");
        rd(BASE + 'h20, 32'h0, "R8");

        // R10: idle and write cycles give no response
        step(1'b0, 1'b1, BASE + 'h20, 32'h0, 32'h0, "R10");
        step(1'b0, 1'b0, BASE + 'h20, 32'h0, 32'h0, "R10");

        // R5: clearing config drops the drive enables
        wr(BASE + ALIAS + 'h00, 32'h0000_0F00, 32'h0, "R5");
        wr(BASE + 'h10, 32'h0000_00FF, 32'h0, "R5");
        step(1'b0, 1'b0, 0, 32'h0, 32'h0, "R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule